// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets logic on a single synchronous clock reach an external asynchronous static RAM. The RAM holds 256K words of 16 bits, split into two byte lanes. A requester presents an 18-bit word address, 16-bit write data, a 2-bit lane mask and a write flag under a valid/ready handshake. The controller then drives the active-low chip select, write enable, output enable and the two lane strobes. It also drives the address bus and a data bus built from separate output data, output-enable and input data signals.

All access timing comes from parameters given in nanoseconds together with the clock period. Each is turned into a whole number of cycles, at least one. Between accesses the chip select is high, so the memory sits in standby. A read returns its data with a one-cycle valid pulse. A write completes silently, and the controller is ready again after the write.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and between accesses, sram_cs_n, sram_we_n, sram_oe_n, sram_ub_n and sram_lb_n are all 1, sram_dq_oe is 0, and req_ready is 1. req_ready is 1 only while no access is in progress.
- R2: A read is accepted when req_valid and req_ready are 1 with req_write = 0 and a nonzero mask. From the next clock edge it holds sram_cs_n = 0, sram_oe_n = 0 and sram_we_n = 1 for exactly RD_CYC cycles. sram_lb_n is the inverse of req_mask[0] (bits 7:0) and sram_ub_n is the inverse of req_mask[1] (bits 15:8).
- R3: rsp_valid is 1 for one cycle, beginning RD_CYC edges after the accepting edge. rsp_rdata carries the lanes sampled at that edge, and every lane whose mask bit was 0 reads as zero.
- R4: An accepted write with a nonzero mask holds sram_we_n = 0 for exactly WR_LOW cycles. During those cycles sram_cs_n = 0, sram_oe_n = 1, the strobes follow the inverted mask, sram_dq_oe = 1 and sram_dq_out = the request's write data. Write enable falls on the same edge as chip select and the strobes.
- R5: After write enable rises, chip select, the strobes and the driven data stay in place for WR_HOLD more cycles. The data bus is then released on the same edge that raises chip select.
- R6: After every read, chip select stays high and the bus undriven for TURN_CYC cycles before another request is accepted.
- R7: A request whose mask is 0 completes in the accepting cycle without lowering chip select. If it is a read, rsp_valid is 1 in the next cycle with rsp_rdata = 0. If it is a write, memory is not touched.
- R8: Each cycle count is max(1, ceil(ns / CLK_NS)). RD_CYC is the largest of the address-access, read-cycle and output-enable counts. WR_LOW is the larger of the write-pulse and data-setup counts. WR_HOLD is the write-cycle count minus WR_LOW, at least 1. TURN_CYC comes from the bus release time. With the defaults at a 10 ns clock these are 6, 5, 1 and 2.
- R9: sram_dq_oe is never 1 while sram_oe_n is 0, and sram_oe_n is always 1 while sram_we_n is 0.
- R10: While chip select stays low, sram_addr and both strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_addr | output | 18 | Address bus |
| sram_dq_out | output | 16 | Data bus output value |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 16 | Data bus input value |

## Verification
The hardest conditions to reach from the ports are a reset that lands in the middle of a write pulse and a write requested right after a read. The bench starts a write, counts cycles until write enable is low, and only then pulls reset. For the read-then-write case it issues the write as soon as ready returns and measures the chip-select-high gap. A behavioural memory in the bench supplies wrong bytes on disabled lanes and returns stale data until the programmed access time has passed. Because of this, a read that is too short, or that fails to mask a lane, shows up as a wrong data word.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_TURN   = 3'd4
  } seq_state_t;

  // whole cycles covering a time in ns, never below one
  function automatic int unsigned wait_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned WR_LOW   = 5,
  parameter int unsigned WR_HOLD  = 1,
  parameter int unsigned TURN_CYC = 2,
  parameter int          CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_any_lane,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             rd_capture,
  output logic             rd_empty,
  output logic             bus_release,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_drive
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LD   = CNT_W'(WR_LOW - 1);
  localparam logic [CNT_W-1:0] WH_LD   = CNT_W'(WR_HOLD - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  seq_state_t state_q, state_d;
  logic cs_q, cs_d, we_q, we_d, oe_q, oe_d, drv_q, drv_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;

  always_comb begin
    state_d     = state_q;
    cs_d        = cs_q;
    we_d        = we_q;
    oe_d        = oe_q;
    drv_d       = drv_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    rd_capture  = 1'b0;
    rd_empty    = 1'b0;
    bus_release = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_any_lane) begin
            rd_empty = !req_write;
          end else if (!req_write) begin
            state_d  = ST_READ;
            cs_d     = 1'b0;
            oe_d     = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end else begin
            state_d  = ST_WPULSE;
            cs_d     = 1'b0;
            we_d     = 1'b0;
            drv_d    = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = WL_LD;
          end
        end
      end
      ST_READ: begin
        if (tmr_zero) begin
          rd_capture  = 1'b1;
          bus_release = 1'b1;
          state_d     = ST_TURN;
          cs_d        = 1'b1;
          oe_d        = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = TURN_LD;
        end
      end
      ST_WPULSE: begin
        if (tmr_zero) begin
          state_d  = ST_WHOLD;
          we_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = WH_LD;
        end
      end
      ST_WHOLD: begin
        if (tmr_zero) begin
          bus_release = 1'b1;
          state_d     = ST_IDLE;
          cs_d        = 1'b1;
          drv_d       = 1'b0;
        end
      end
      ST_TURN: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cs_d    = 1'b1;
        we_d    = 1'b1;
        oe_d    = 1'b1;
        drv_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      drv_q   <= drv_d;
    end
  end

  assign cs_n     = cs_q;
  assign we_n     = we_q;
  assign oe_n     = oe_q;
  assign dq_drive = drv_q;

endmodule

// File: rtl/sram_lane_dpath.sv
`timescale 1ns/1ps
module sram_lane_dpath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              bus_release,
  input  logic              rd_capture,
  input  logic              rd_empty,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic [LANES-1:0]  strobe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  strobe_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] merged;
  logic              rsp_q;

  // each lane passes only if its mask bit was set
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      mask_q[l] ? sram_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '1;
    end else if (accept) begin
      strobe_q <= ~req_mask;
    end else if (bus_release) begin
      strobe_q <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_capture) begin
      rdata_q <= merged;
    end else if (rd_empty) begin
      rdata_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= rd_capture | rd_empty;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign strobe_n    = strobe_q;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_OE_NS  = 30,
  parameter int unsigned T_WP_NS  = 45,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_DW_NS  = 25,
  parameter int unsigned T_REL_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int          LANES    = 2;
  localparam int unsigned RD_CYC   = max_u(max_u(wait_cycles(T_AA_NS, CLK_NS),
                                                 wait_cycles(T_RC_NS, CLK_NS)),
                                           wait_cycles(T_OE_NS, CLK_NS));
  localparam int unsigned WR_LOW   = max_u(wait_cycles(T_WP_NS, CLK_NS),
                                           wait_cycles(T_DW_NS, CLK_NS));
  localparam int unsigned WC_CYC   = wait_cycles(T_WC_NS, CLK_NS);
  localparam int unsigned WR_HOLD  = (WC_CYC > WR_LOW + 1) ? (WC_CYC - WR_LOW) : 1;
  localparam int unsigned TURN_CYC = wait_cycles(T_REL_NS, CLK_NS);
  localparam int unsigned MAX_CYC  = max_u(max_u(RD_CYC, WR_LOW), max_u(WR_HOLD, TURN_CYC));
  localparam int          CNT_W    = $clog2(MAX_CYC + 1);

  logic             rst_meta_q, rst_sync_n;
  logic             accept, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             rd_capture, rd_empty, bus_release;
  logic [LANES-1:0] strobe_n;

  // reset asserts at once and releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_lane_seq #(
    .RD_CYC   (RD_CYC),
    .WR_LOW   (WR_LOW),
    .WR_HOLD  (WR_HOLD),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_any_lane (|req_mask),
    .tmr_zero     (tmr_zero),
    .req_ready    (req_ready),
    .accept       (accept),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .rd_capture   (rd_capture),
    .rd_empty     (rd_empty),
    .bus_release  (bus_release),
    .cs_n         (sram_cs_n),
    .we_n         (sram_we_n),
    .oe_n         (sram_oe_n),
    .dq_drive     (sram_dq_oe)
  );

  sram_lane_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_mask    (req_mask),
    .bus_release (bus_release),
    .rd_capture  (rd_capture),
    .rd_empty    (rd_empty),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .strobe_n    (strobe_n),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  assign sram_lb_n = strobe_n[0];
  assign sram_ub_n = strobe_n[1];

endmodule

// File: rtl/sram_lane_chk.sv
`timescale 1ns/1ps
module sram_lane_chk #(
  parameter int          ADDR_W = 18,
  parameter int unsigned WR_LOW = 5,
  parameter int unsigned RD_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              ub_n,
  input logic              lb_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);

  logic [7:0] we_run_q;
  logic [7:0] oe_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= we_n ? 8'd0 : ((we_run_q == 8'hFF) ? we_run_q : we_run_q + 8'd1);
      oe_run_q <= oe_n ? 8'd0 : ((oe_run_q == 8'hFF) ? oe_run_q : oe_run_q + 8'd1);
    end
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (we_n && oe_n && ub_n && lb_n && !dq_oe));

  assert_ready_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  assert_read_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n && !(ub_n && lb_n)));

  assert_write_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && dq_oe && !(ub_n && lb_n)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && $past(!we_n)) |-> (dq_oe && !cs_n));

  assert_write_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && $past(!we_n)) |-> (32'(we_run_q) >= WR_LOW));

  assert_read_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && $past(!oe_n)) |-> (32'(oe_run_q) >= RD_CYC));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n) && (!we_n -> oe_n));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(ub_n) && $stable(lb_n)));

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W (ADDR_W),
  .WR_LOW (WR_LOW),
  .RD_CYC (RD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_ready (req_ready),
  .cs_n      (sram_cs_n),
  .we_n      (sram_we_n),
  .oe_n      (sram_oe_n),
  .ub_n      (sram_ub_n),
  .lb_n      (sram_lb_n),
  .dq_oe     (sram_dq_oe),
  .addr      (sram_addr)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  // expected counts worked out from R8
  localparam int RD_EXP   = (cyc(55) > cyc(30)) ? cyc(55) : cyc(30);
  localparam int WL_EXP   = (cyc(45) > cyc(25)) ? cyc(45) : cyc(25);
  localparam int WH_EXP   = (cyc(55) > WL_EXP + 1) ? cyc(55) - WL_EXP : 1;
  localparam int TA_EXP   = cyc(20);
  localparam int GAP_RD   = (TA_EXP + 1 > 2) ? TA_EXP + 1 : 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [17:0] sram_addr;
  logic [15:0] sram_dq_out;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_in;

  sram_lane_ctrl #(.CLK_NS(CLK_PERIOD)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with byte lanes ----------------
  logic [15:0] mem [256];
  int          rd_age;
  int          viol = 0;
  int          we_cnt = 0;
  logic        we_prev = 1'b1;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (!sram_cs_n && !sram_oe_n && sram_we_n) rd_age <= rd_age + 1;
    else rd_age <= 0;
  end

  // stale bytes until access time passes, junk on disabled lanes
  always_comb begin
    sram_dq_in = 16'hEEEE;
    if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
      if (!sram_lb_n) sram_dq_in[7:0]  = (rd_age >= RD_EXP - 1) ? mem[sram_addr[7:0]][7:0]  : 8'h5A;
      if (!sram_ub_n) sram_dq_in[15:8] = (rd_age >= RD_EXP - 1) ? mem[sram_addr[7:0]][15:8] : 8'h5A;
    end
  end

  always @(negedge clk) begin
    if (sram_dq_oe && !sram_oe_n) viol++;
    if (!we_prev && sram_we_n && !sram_cs_n) begin
      if (we_cnt < WL_EXP || !sram_dq_oe) viol++;
      if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  = sram_dq_out[7:0];
      if (!sram_ub_n) mem[sram_addr[7:0]][15:8] = sram_dq_out[15:8];
    end
    we_cnt  = sram_we_n ? 0 : we_cnt + 1;
    we_prev = sram_we_n;
  end

  // ---------------- port monitors ----------------
  int we_run = 0, last_we_run = 0;
  int cs_run = 0, last_cs_run = 0;
  int gap_run = 0, last_gap = 0;
  int cs_falls = 0, addr_viol = 0;
  logic [17:0] addr_at_fall;
  logic [1:0]  strb_at_fall;

  always @(negedge clk) begin
    if (!sram_we_n) we_run++;
    else if (we_run > 0) begin last_we_run = we_run; we_run = 0; end
    if (!sram_cs_n) begin
      if (cs_run == 0) begin
        cs_falls++;
        last_gap = gap_run;
        gap_run = 0;
        addr_at_fall = sram_addr;
        strb_at_fall = {sram_ub_n, sram_lb_n};
      end else if (sram_addr != addr_at_fall || {sram_ub_n, sram_lb_n} != strb_at_fall) begin
        addr_viol++;
      end
      cs_run++;
    end else begin
      if (cs_run > 0) begin last_cs_run = cs_run; cs_run = 0; end
      gap_run++;
    end
  end

  task automatic do_req(input bit w, input logic [17:0] a, input logic [1:0] m,
                        input logic [15:0] d, output logic [15:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_mask = m; req_wdata = d;
    rd = '0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!w) begin
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
    end else begin
      while (!req_ready) @(negedge clk);
    end
    #1;
  endtask

  // {write, mask, addr, wdata, expected read}
  localparam logic [52:0] VEC [0:12] = '{
    {1'b1, 2'b11, 18'h00010, 16'hA5C3, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA5C3},
    {1'b1, 2'b01, 18'h00010, 16'h1177, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA577},
    {1'b1, 2'b10, 18'h00010, 16'h8800, 16'h0000},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h8877},
    {1'b0, 2'b01, 18'h00010, 16'h0000, 16'h0077},
    {1'b0, 2'b10, 18'h00010, 16'h0000, 16'h8800},
    {1'b1, 2'b11, 18'h3FF20, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 18'h3FF20, 16'h0000, 16'h0F0F},
    {1'b1, 2'b11, 18'h00011, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 18'h00011, 16'h0000, 16'hFFFF},
    {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h8877}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int lat, falls0;
    bit prev_read;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sram_cs_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n,
        "R1 strobes high in reset", {sram_cs_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 5'h1F);
    chk(!sram_dq_oe && !rsp_valid, "R1 bus idle in reset", {sram_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    prev_read = 1'b0;
    for (int i = 0; i < 13; i++) begin
      do_req(VEC[i][52], VEC[i][49:32], VEC[i][51:50], VEC[i][31:16], rd, lat);
      if (VEC[i][52]) begin
        chk(last_we_run == WL_EXP, $sformatf("R4 write pulse vec %0d", i), last_we_run, WL_EXP);
        chk(last_cs_run == WL_EXP + WH_EXP, $sformatf("R5 write select vec %0d", i),
            last_cs_run, WL_EXP + WH_EXP);
      end else begin
        chk(rd == VEC[i][15:0], $sformatf("R3 read data vec %0d", i), rd, VEC[i][15:0]);
        chk(lat == RD_EXP + 1, $sformatf("R3 read latency vec %0d", i), lat, RD_EXP + 1);
        chk(last_cs_run == RD_EXP, $sformatf("R2 read select vec %0d", i), last_cs_run, RD_EXP);
      end
      if (prev_read) chk(last_gap == GAP_RD, $sformatf("R6 turnaround vec %0d", i), last_gap, GAP_RD);
      prev_read = !VEC[i][52];
    end

    // R7: empty-mask write leaves memory and chip select alone
    falls0 = cs_falls;
    do_req(1'b1, 18'h00010, 2'b00, 16'h0000, rd, lat);
    chk(cs_falls == falls0, "R7 empty write no select", cs_falls - falls0, 0);
    chk(lat == 1, "R7 empty write one cycle", lat, 1);
    do_req(1'b0, 18'h00010, 2'b11, 16'h0000, rd, lat);
    chk(rd == 16'h8877, "R7 empty write left data", rd, 16'h8877);
    // R7: empty-mask read
    falls0 = cs_falls;
    do_req(1'b0, 18'h00011, 2'b00, 16'h0000, rd, lat);
    chk(lat == 1 && rd == 16'h0000, "R7 empty read", {lat[15:0], rd}, 32'h00010000);
    chk(cs_falls == falls0, "R7 empty read no select", cs_falls - falls0, 0);

    // R1: reset in the middle of a write pulse
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00030; req_mask = 2'b11; req_wdata = 16'h1234;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!sram_we_n, "R4 write pulse under way", sram_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(sram_cs_n && sram_we_n && !sram_dq_oe, "R1 reset aborts write",
        {sram_cs_n, sram_we_n, sram_dq_oe}, 3'b110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && sram_cs_n, "R1 ready after mid-write reset", {req_ready, sram_cs_n}, 2'b11);

    // R8 R9 R10: pulse widths, contention, stability seen by the memory model
    chk(viol == 0, "R9 model timing or contention", viol, 0);
    chk(addr_viol == 0, "R10 address and strobes stable", addr_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule